// File: doc/BRIEF.md
# Infrared Edge Interval Timer

This block timestamps a demodulated infrared line for software decoding. It divides the system clock into a programmable tick and counts ticks from one input transition to the next. Each selected transition stores the measured interval and the level of the segment that just ended, and raises a one-cycle interrupt. Software reads these values and rebuilds the mark and space durations. A mark is a high input level and a space is a low input level.

The input passes through a two-stage synchroniser before edge detection. Every detected transition restarts the interval count and the tick prescaler. Only transitions chosen by the interrupt selector update the stored values. The selector can also pass a decoder-complete strobe through as the interrupt. An enable input gates all activity. A clear input zeroes the count and the stored values while it is high.

Top module: `ir_edge_timer`

## Requirements
- R1: After reset, and in the cycle after `cfg_clear` is high, `cap_interval` is 0, `cap_level` is 0 and `irq` is 0.
- R2: One tick lasts `cfg_tick_div`+1 clock cycles. The prescaler restarts on every detected transition. If the input changes at two moments N cycles apart, the stored interval is floor(N/(`cfg_tick_div`+1)).
- R3: The interval count saturates at 8191 (13 bits all ones) and does not wrap.
- R4: `cap_level` is 1 when the segment that just ended was high (a mark, stored on a falling transition). It is 0 when that segment was low (a space, stored on a rising transition).
- R5: `cfg_irq_sel` encodes the interrupt source: 0 = decoder-complete strobe, 1 = both transitions, 2 = falling transitions only, 3 = rising transitions only.
- R6: For a selected transition, `irq` is high for exactly one cycle, after the third rising clock edge following the input change. `cap_interval` and `cap_level` update in that same cycle.
- R7: A transition that the selector does not choose leaves `cap_interval`, `cap_level` and `irq` unchanged.
- R8: While `cfg_enable` is 0, no values are stored and `irq` stays 0, and the count is held at zero. Counting resumes on the first clock after enable rises. With a one-cycle tick, a change made n cycles after enable rises stores n+3.
- R9: With source 0, a `dec_done` pulse gives a one-cycle `irq` on the next clock, and input transitions store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, high = mark |
| dec_done | input | 1 | Decoder-complete strobe |
| cfg_enable | input | 1 | Enables counting and capture |
| cfg_clear | input | 1 | Synchronous clear of the count and the stored values |
| cfg_tick_div | input | 12 | Tick period minus one, in clock cycles |
| cfg_irq_sel | input | 2 | Interrupt source select |
| cap_interval | output | 13 | Ticks in the segment that just ended |
| cap_level | output | 1 | Level of that segment, 1 = mark |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench checks intervals at several prescaler values, including segments shorter than one tick. A design that lets the tick phase run across transitions, or samples the count one cycle late, misses these values by one tick. A gap longer than full scale must read 8191; a wrapping counter would report a small number. The bench drives transitions the selector rejects, in each single-edge mode and in decoder mode, and checks that the stored values survive them. A design that stores on every transition would overwrite them. It also checks the interval of the first change after enable rises, which exposes a count that was not held at zero while disabled.

// File: rtl/ir_edge_pkg.sv
package ir_edge_pkg;

  typedef enum logic [1:0] {
    IRQ_DECODER = 2'd0,
    IRQ_BOTH    = 2'd1,
    IRQ_FALL    = 2'd2,
    IRQ_RISE    = 2'd3
  } irq_sel_e;

  // Whether an input transition is one the selector stores and reports.
  function automatic logic edge_selected(input irq_sel_e sel,
                                         input logic rise, input logic fall);
    case (sel)
      IRQ_BOTH: return rise | fall;
      IRQ_FALL: return fall;
      IRQ_RISE: return rise;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ir_in_sync.sv
module ir_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre;

  assign tick = run && (pre >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (!run || restart)  pre <= '0;
    else if (pre >= div)       pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  // R2: with a divider above zero, ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/ir_ivl_counter.sv
module ir_ivl_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         tick,
  output logic [W-1:0] cnt_adv
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == FULL) ? v : v + 1'b1;
  endfunction

  // Count including this cycle's tick: the value the stored interval takes.
  assign cnt_adv = tick ? sat_inc(cnt_q) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else                      cnt_q <= cnt_adv;
  end

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart) |=> (cnt_q == '0));

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cnt_q == FULL) |=> (cnt_q == FULL));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer
  import ir_edge_pkg::*;
#(
  parameter int IVL_W       = 13,
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             dec_done,
  input  logic             cfg_enable,
  input  logic             cfg_clear,
  input  logic [DIV_W-1:0] cfg_tick_div,
  input  logic [1:0]       cfg_irq_sel,
  output logic [IVL_W-1:0] cap_interval,
  output logic             cap_level,
  output logic             irq
);
  irq_sel_e         sel;
  logic             run, rise, fall, any_edge, tick;
  logic             cap_load, irq_set;
  logic [IVL_W-1:0] cnt_adv;

  assign sel      = irq_sel_e'(cfg_irq_sel);
  assign run      = cfg_enable & ~cfg_clear;
  assign any_edge = rise | fall;

  ir_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_in), .rise(rise), .fall(fall)
  );

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(any_edge),
    .div(cfg_tick_div), .tick(tick)
  );

  ir_ivl_counter #(.W(IVL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(any_edge),
    .tick(tick), .cnt_adv(cnt_adv)
  );

  assign cap_load = run & edge_selected(sel, rise, fall);
  assign irq_set  = run & ((sel == IRQ_DECODER) ? dec_done : cap_load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_interval <= '0;
      cap_level    <= 1'b0;
      irq          <= 1'b0;
    end else if (cfg_clear) begin
      cap_interval <= '0;
      cap_level    <= 1'b0;
      irq          <= 1'b0;
    end else begin
      irq <= irq_set;
      if (cap_load) begin
        cap_interval <= cnt_adv;
        cap_level    <= fall;   // falling transition closes a mark
      end
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (cap_interval == '0 && !cap_level && !irq));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_load && !cfg_clear) |=> ($stable(cap_interval) && $stable(cap_level)));

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !irq);

endmodule

// File: tb/ir_edge_timer_tb.sv
module ir_edge_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        dec_done = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_clear = 1'b0;
  logic [11:0] cfg_tick_div = '0;
  logic [1:0]  cfg_irq_sel = 2'd1;
  logic [12:0] cap_interval;
  logic        cap_level;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ir_edge_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .dec_done(dec_done),
    .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
    .cfg_tick_div(cfg_tick_div), .cfg_irq_sel(cfg_irq_sel),
    .cap_interval(cap_interval), .cap_level(cap_level), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_ivl(input int n, input int div);
    int q = n / (div + 1);
    return (q > 8191) ? 8191 : q;
  endfunction

  task automatic settle_low();
    @(negedge clk); ir_in = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset interval", cap_interval, 0);
    check("R1 reset level", cap_level, 0);
    check("R1 reset irq", irq, 0);
  endtask

  // High segment of n cycles, closed by a falling transition.
  task automatic t_mark(input int div, input int n);
    cfg_irq_sel = 2'd1; cfg_tick_div = 12'(div);
    settle_low();
    ir_in = 1'b1;
    repeat (n) @(negedge clk);
    ir_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 irq not early", irq, 0);
    @(negedge clk);
    check("R6 irq raised", irq, 1);
    check("R2 mark interval", cap_interval, expect_ivl(n, div));
    check("R4 mark level", cap_level, 1);
    @(negedge clk);
    check("R6 irq one cycle", irq, 0);
  endtask

  // Low segment of n cycles, closed by a rising transition.
  task automatic t_space(input int div, input int n);
    cfg_irq_sel = 2'd1; cfg_tick_div = 12'(div);
    settle_low();
    ir_in = 1'b1;
    repeat (20) @(negedge clk);
    ir_in = 1'b0;
    repeat (n) @(negedge clk);
    ir_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 space irq", irq, 1);
    check("R2 space interval", cap_interval, expect_ivl(n, div));
    check("R4 space level", cap_level, 0);
    settle_low();
  endtask

  task automatic t_rise_only();
    logic [12:0] held;
    cfg_irq_sel = 2'd3; cfg_tick_div = 12'd0;
    settle_low();
    ir_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 rise mode irq", irq, 1);
    check("R5 rise mode level", cap_level, 0);
    held = cap_interval;
    repeat (10) @(negedge clk);
    ir_in = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 fall ignored irq", irq, 0);
    end
    check("R7 fall ignored interval", cap_interval, held);
    check("R7 fall ignored level", cap_level, 0);
  endtask

  task automatic t_fall_only();
    cfg_irq_sel = 2'd2; cfg_tick_div = 12'd0;
    settle_low();
    ir_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5 rise ignored irq", irq, 0);
    end
    repeat (7) @(negedge clk);
    ir_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 fall mode irq", irq, 1);
    check("R5 fall mode interval", cap_interval, 12);
    check("R4 fall mode level", cap_level, 1);
  endtask

  task automatic t_decoder();
    logic [12:0] held;
    cfg_irq_sel = 2'd0;
    settle_low();
    held = cap_interval;
    dec_done = 1'b1;
    @(negedge clk);
    dec_done = 1'b0;
    check("R9 strobe irq", irq, 1);
    @(negedge clk);
    check("R9 strobe one cycle", irq, 0);
    ir_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 edge no irq", irq, 0);
    end
    check("R9 edge not stored", cap_interval, held);
  endtask

  task automatic t_saturate();
    t_mark(0, 9000);
  endtask

  task automatic t_disable();
    logic [12:0] held;
    cfg_irq_sel = 2'd1; cfg_tick_div = 12'd0;
    settle_low();
    cfg_enable = 1'b0;
    held = cap_interval;
    ir_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8 disabled irq", irq, 0);
    end
    check("R8 disabled no store", cap_interval, held);
    repeat (10) @(negedge clk);
    cfg_enable = 1'b1;
    repeat (50) @(negedge clk);
    ir_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 resume irq", irq, 1);
    check("R8 resume interval", cap_interval, 53);
  endtask

  task automatic t_clear();
    t_mark(0, 30);
    @(negedge clk); cfg_clear = 1'b1;
    @(negedge clk); cfg_clear = 1'b0;
    check("R1 clear interval", cap_interval, 0);
    check("R1 clear level", cap_level, 0);
    check("R1 clear irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1;
    t_mark(0, 10);
    t_mark(4, 23);
    t_mark(9, 100);
    t_mark(2, 2);
    t_space(3, 41);
    t_saturate();
    t_rise_only();
    t_fall_only();
    t_decoder();
    t_disable();
    t_clear();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule